// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked stand-in for a retriggerable monostable timer that has a direct clear. Three asynchronous control pins feed it. A falling edge on `arm_fall_i` can fire it. So can a rising edge on `arm_rise_i`. The active-low clear pin `clear_n_i` can also fire it on its rising edge. Each of these edges counts only when the other two pins hold their enabling levels. Once fired, the block drives `pulse_o` high and `pulse_n_o` low for a number of clock cycles taken from `width_i`. The width value plays the part that an external resistor and capacitor would play in an analog part.

A new valid edge during a running pulse reloads the full width. A steady stream of edges therefore keeps the output high for as long as the stream lasts. A falling edge on the clear pin ends the pulse at once. While the clear pin stays low, every trigger is blocked.

All three pins pass through a two-flop synchronizer before edge detection. The system reset `rst_n` clears the block asynchronously. It is assumed to be released synchronously to `clk`.

Top module: `pulse_retrig_oneshot`

## Requirements
- R1: While `rst_n` is low and after it is released, `pulse_o` is 0 and `pulse_n_o` is 1. Pin levels held through reset produce no pulse.
- R2: A falling edge on `arm_fall_i` fires the block when `arm_rise_i` and `clear_n_i` are both high. `pulse_o` goes high on the third rising clock edge after the pin changes.
- R3: A rising edge on `arm_rise_i` fires the block when `arm_fall_i` is low and `clear_n_i` is high. The latency is the same as in R2.
- R4: A rising edge on `clear_n_i` fires the block when `arm_fall_i` is low and `arm_rise_i` is high.
- R5: An edge whose gating levels are not met is ignored and `pulse_o` stays low. Examples are a falling `arm_fall_i` while `arm_rise_i` is low, and a rising `arm_rise_i` while `arm_fall_i` is high.
- R6: A pulse lasts exactly `width_i` clock cycles, using the value present when the trigger is taken. A width of 0 gives no pulse.
- R7: A trigger taken during a pulse reloads the full width. The total high time is the gap from the first trigger to the last trigger, plus `width_i`.
- R8: A falling edge on `clear_n_i` ends a running pulse. `pulse_o` goes low on the third rising clock edge after the pin falls.
- R9: While `clear_n_i` is low, no trigger edge on `arm_fall_i` or `arm_rise_i` starts a pulse.
- R10: When a trigger edge and a falling edge on `clear_n_i` arrive in the same cycle, the clear wins and the pulse ends.
- R11: `pulse_n_o` is always the complement of `pulse_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| arm_fall_i | input | 1 | Trigger pin, active on its falling edge (asynchronous) |
| arm_rise_i | input | 1 | Trigger pin, active on its rising edge (asynchronous) |
| clear_n_i | input | 1 | Active-low clear; its rising edge also triggers (asynchronous) |
| width_i | input | WIDTH | Pulse length in clock cycles |
| pulse_o | output | 1 | High during the pulse |
| pulse_n_o | output | 1 | Low during the pulse |

## Verification
The bench builds the block with `WIDTH` = 6 instead of the default 16. With that setting, the all-ones width of 63 cycles can be timed cycle by cycle in a short run, and reaching it checks that the counter reloads and counts down cleanly across its whole range. The synchronizer depth stays at 2, so every expected rise and fall is placed three clock edges after the pin change that causes it. Retrigger, clear and collision cases are timed with gaps shorter than the programmed width, so each one cuts or stretches a live pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Synchronized view of the three control pins
  typedef struct packed {
    logic fall_pin;
    logic rise_pin;
    logic clr_pin;
  } pin_vec_t;

  localparam int unsigned PIN_COUNT        = 3;
  localparam int unsigned SYNC_DEPTH       = 2;
  // Reset image chosen so that no edge can appear on the first cycles after reset:
  // fall pin starts low (cannot fall), rise pin starts high (cannot rise),
  // clear pin starts high (cannot rise).
  localparam pin_vec_t    PIN_RESET_IMAGE  = '{fall_pin: 1'b0, rise_pin: 1'b1, clr_pin: 1'b1};

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int unsigned       W       = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= RST_VAL;
        end else begin
          stage_q[g] <= stage_d;
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/oneshot_trig_gate.sv
module oneshot_trig_gate
  import oneshot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_vec_t cur_i,
  output logic     trig_o,
  output logic     clr_fall_o,
  output logic     clr_low_o
);

  pin_vec_t prev_q;
  logic     fall_edge;
  logic     rise_edge;
  logic     clr_rise_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= PIN_RESET_IMAGE;
    end else begin
      prev_q <= cur_i;
    end
  end

  always_comb begin
    // each edge is qualified by the present levels of the other two pins
    fall_edge     = prev_q.fall_pin & ~cur_i.fall_pin & cur_i.rise_pin & cur_i.clr_pin;
    rise_edge     = ~prev_q.rise_pin & cur_i.rise_pin & ~cur_i.fall_pin & cur_i.clr_pin;
    clr_rise_edge = ~prev_q.clr_pin & cur_i.clr_pin & ~cur_i.fall_pin & cur_i.rise_pin;
    trig_o        = fall_edge | rise_edge | clr_rise_edge;
    clr_fall_o    = prev_q.clr_pin & ~cur_i.clr_pin;
    clr_low_o     = ~cur_i.clr_pin;
  end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] width_i,
  output logic             active_o
);

  localparam logic [WIDTH-1:0] CNT_ZERO = '0;
  localparam logic [WIDTH-1:0] CNT_ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;
  logic             running;

  assign running = (cnt_q != CNT_ZERO);

  // next-state: clear has priority over load, load over countdown
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = CNT_ZERO;
      cnt_en = running;
    end else if (load_i) begin
      cnt_d  = width_i;
      cnt_en = 1'b1;
    end else if (running) begin
      cnt_d  = cnt_q - CNT_ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active_o = running;

endmodule

// File: rtl/pulse_retrig_oneshot.sv
module pulse_retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_fall_i,
  input  logic             arm_rise_i,
  input  logic             clear_n_i,
  input  logic [WIDTH-1:0] width_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  pin_vec_t raw_pins;
  pin_vec_t sync_pins;
  logic     trig_evt;
  logic     clr_fall_evt;
  logic     clr_low_lvl;
  logic     active;

  assign raw_pins = '{fall_pin: arm_fall_i, rise_pin: arm_rise_i, clr_pin: clear_n_i};

  oneshot_sync #(
    .W       (PIN_COUNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RESET_IMAGE)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_pins),
    .sync_o  (sync_pins)
  );

  oneshot_trig_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_i      (sync_pins),
    .trig_o     (trig_evt),
    .clr_fall_o (clr_fall_evt),
    .clr_low_o  (clr_low_lvl)
  );

  oneshot_timer #(
    .WIDTH (WIDTH)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (trig_evt),
    .clear_i  (clr_low_lvl),
    .width_i  (width_i),
    .active_o (active)
  );

  assign pulse_o   = active;
  assign pulse_n_o = ~active;

endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             clr_fall,
  input logic             clr_low,
  input logic [WIDTH-1:0] width,
  input logic             pulse_o
);

  assert_clear_ends_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> !pulse_o);

  assert_no_trigger_while_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_low |=> !pulse_o);

  assert_trigger_starts_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !clr_low && (width != '0)) |=> pulse_o);

  assert_zero_width_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && (width == '0)) |=> !pulse_o);

  assert_rise_needs_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(trig));

endmodule

bind pulse_retrig_oneshot oneshot_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig     (trig_evt),
  .clr_fall (clr_fall_evt),
  .clr_low  (clr_low_lvl),
  .width    (width_i),
  .pulse_o  (pulse_o)
);

// File: tb/tb_pulse_retrig_oneshot.sv
module tb_pulse_retrig_oneshot;

  localparam int unsigned WIDTH = 6;

  logic             clk;
  logic             rst_n;
  logic             arm_fall_i;
  logic             arm_rise_i;
  logic             clear_n_i;
  logic [WIDTH-1:0] width_i;
  logic             pulse_o;
  logic             pulse_n_o;

  int    n_checks;
  int    n_fails;
  int    exp_len_q[$];
  string exp_tag_q[$];
  int    run_len;

  pulse_retrig_oneshot #(.WIDTH(WIDTH)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_fall_i (arm_fall_i),
    .arm_rise_i (arm_rise_i),
    .clear_n_i  (clear_n_i),
    .width_i    (width_i),
    .pulse_o    (pulse_o),
    .pulse_n_o  (pulse_n_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_pulse(input int len, input string tag);
    exp_len_q.push_back(len);
    exp_tag_q.push_back(tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // monitor: complement check each cycle, pulse length compare at pulse end
  always @(negedge clk) begin
    if (rst_n) begin
      check(pulse_n_o == !pulse_o, "R11", int'(pulse_n_o), int'(!pulse_o));
      if (pulse_o) begin
        run_len++;
      end else if (run_len > 0) begin
        if (exp_len_q.size() == 0) begin
          check(1'b0, "R5 unexpected pulse", run_len, 0);
        end else begin
          automatic int    e = exp_len_q.pop_front();
          automatic string t = exp_tag_q.pop_front();
          check(run_len == e, t, run_len, e);
        end
        run_len = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    n_checks   = 0;
    n_fails    = 0;
    run_len    = 0;
    rst_n      = 1'b0;
    arm_fall_i = 1'b0;
    arm_rise_i = 1'b0;
    clear_n_i  = 1'b1;
    width_i    = 6'd5;
    tick(3);
    check(pulse_o == 1'b0 && pulse_n_o == 1'b1, "R1 in reset", int'(pulse_o), 0);
    rst_n = 1'b1;
    tick(6);
    check(pulse_o == 1'b0, "R1 after release", int'(pulse_o), 0);

    // R3: rising edge on arm_rise with arm_fall low, latency of three edges
    expect_pulse(5, "R3 width");
    arm_rise_i = 1'b1;
    tick(2);
    check(pulse_o == 1'b0, "R3 before latency", int'(pulse_o), 0);
    tick(1);
    check(pulse_o == 1'b1, "R3 after latency", int'(pulse_o), 1);
    arm_rise_i = 1'b0;
    tick(10);

    // R5: arm_rise edge while arm_fall high is ignored
    width_i    = 6'd7;
    arm_fall_i = 1'b1;
    tick(4);
    arm_rise_i = 1'b1;
    tick(6);
    check(pulse_o == 1'b0, "R5 rise gated by fall pin", int'(pulse_o), 0);

    // R2: falling edge on arm_fall with arm_rise high
    expect_pulse(7, "R2 width");
    arm_fall_i = 1'b0;
    tick(2);
    check(pulse_o == 1'b0, "R2 before latency", int'(pulse_o), 0);
    tick(1);
    check(pulse_o == 1'b1, "R2 after latency", int'(pulse_o), 1);
    tick(12);

    // R4: clear pin rising edge fires with arm_fall low, arm_rise high
    width_i = 6'd4;
    expect_pulse(4, "R4 width");
    clear_n_i = 1'b0;
    tick(4);
    clear_n_i = 1'b1;
    tick(2);
    check(pulse_o == 1'b0, "R4 before latency", int'(pulse_o), 0);
    tick(1);
    check(pulse_o == 1'b1, "R4 after latency", int'(pulse_o), 1);
    tick(8);

    // R5: arm_fall edge while arm_rise low is ignored
    arm_rise_i = 1'b0;
    arm_fall_i = 1'b1;
    tick(4);
    arm_fall_i = 1'b0;
    tick(6);
    check(pulse_o == 1'b0, "R5 fall gated by rise pin", int'(pulse_o), 0);

    // R6: zero width gives no pulse
    width_i    = 6'd0;
    arm_rise_i = 1'b1;
    tick(6);
    check(pulse_o == 1'b0, "R6 zero width", int'(pulse_o), 0);
    arm_rise_i = 1'b0;
    tick(4);

    // R6: all-ones width
    width_i = 6'd63;
    expect_pulse(63, "R6 max width");
    arm_rise_i = 1'b1;
    tick(2);
    arm_rise_i = 1'b0;
    tick(70);

    // R7: one retrigger four cycles after the first
    width_i = 6'd10;
    expect_pulse(14, "R7 single retrigger");
    arm_rise_i = 1'b1;
    tick(2);
    arm_rise_i = 1'b0;
    tick(2);
    arm_rise_i = 1'b1;
    tick(2);
    arm_rise_i = 1'b0;
    tick(20);

    // R7: five triggers four cycles apart stretch the pulse
    width_i = 6'd6;
    expect_pulse(22, "R7 stretched");
    for (int i = 0; i < 5; i++) begin
      arm_rise_i = 1'b1;
      tick(2);
      arm_rise_i = 1'b0;
      tick(2);
    end
    tick(20);

    // R8: clear falling edge cuts a running pulse after seven cycles
    width_i = 6'd20;
    expect_pulse(7, "R8 early end");
    arm_rise_i = 1'b1;
    tick(2);
    arm_rise_i = 1'b0;
    tick(5);
    clear_n_i = 1'b0;
    tick(6);
    check(pulse_o == 1'b0, "R8 pulse ended", int'(pulse_o), 0);
    clear_n_i = 1'b1;
    tick(6);
    check(pulse_o == 1'b0, "R4 clear rise gated by rise pin", int'(pulse_o), 0);

    // R9: triggers blocked while clear is low
    clear_n_i = 1'b0;
    tick(3);
    arm_rise_i = 1'b1;
    tick(6);
    check(pulse_o == 1'b0, "R9 rise edge blocked", int'(pulse_o), 0);
    arm_rise_i = 1'b0;
    tick(3);
    clear_n_i = 1'b1;
    tick(6);
    check(pulse_o == 1'b0, "R9 no late pulse", int'(pulse_o), 0);

    // R10: retrigger and clear falling edge in the same cycle, clear wins
    expect_pulse(5, "R10 clear wins");
    arm_rise_i = 1'b1;
    tick(2);
    arm_rise_i = 1'b0;
    tick(3);
    arm_rise_i = 1'b1;
    clear_n_i  = 1'b0;
    tick(6);
    check(pulse_o == 1'b0, "R10 pulse ended", int'(pulse_o), 0);
    arm_rise_i = 1'b0;
    tick(3);
    clear_n_i = 1'b1;
    tick(6);

    check(exp_len_q.size() == 0, "R6 all pulses seen", exp_len_q.size(), 0);
    summary();
    $finish;
  end

endmodule